// File: doc/BRIEF.md
# Flash Command Sequence Controller

This block is the control logic inside a byte-wide parallel flash device. A host drives chip enable, write enable and output enable strobes together with an address and a data byte. The block decodes keyed unlock sequences from those writes. Each sequence begins with two fixed key writes to two fixed addresses. The decoded sequences start four kinds of action: a byte program, a whole-array erase, a one-way write lock on the bottom (boot) region, and entry to or exit from an identification read mode.

Program and erase do not model real cell timing. Each one keeps the device busy for a parameterized number of clock cycles. While the device is busy, a read returns a status byte instead of array data. Bit 7 of that byte is the inverse of bit 7 of the last data written. Bit 6 changes on each new read. The storage is a small register array whose depth is a parameter. Erased bytes read FF, and programming can only clear bits.

The host-side data bus is split into a data output `dout` and a drive enable `dout_oe`. The pad level outside this block turns these into a tristate pin.

Top module: `pflash_seq_ctrl`

## Requirements
- R1: After reset every array byte reads FF, the device is idle, the boot lock is clear and identification mode is off.
- R2: `dout_oe` is 1 exactly when `ce_n` and `oe_n` are both low. While `dout_oe` is 0, `dout` is 00.
- R3: Byte program uses three key writes: AA to 5555h, 55 to 2AAAh, A0 to 5555h. The next write updates the byte at its own address to old value AND written data. The key compare uses only address bits 14..0, so address bits 17..15 do not matter.
- R4: A write that does not match the next expected step sends the decoder back to idle. That write and the steps before it change nothing.
- R5: Chip erase uses six key writes: AA/5555h, 55/2AAAh, 80/5555h, AA/5555h, 55/2AAAh, 10/5555h. It sets every byte outside the locked boot region to FF.
- R6: The same six-write prefix ending in 40 to 5555h sets the boot lock. The lock clears only on reset. While it is set, neither program nor erase changes the boot bytes, which are array indices below 2**BOOT_AW (16 by default).
- R7: The key writes AA/5555h, 55/2AAAh, 90/5555h enter identification mode. In that mode, a read of address 0 gives DA, address 1 gives 8C, address 2 gives the boot lock in bit 0 with bits 7..1 zero, and any other address gives 00.
- R8: The key writes AA/5555h, 55/2AAAh, F0/5555h leave identification mode, and reads return array data again.
- R9: While busy, every read returns a status byte. Bit 7 is the inverse of bit 7 of the last programmed data, or 0 during an erase. Bits 5..0 are 0.
- R10: While busy, bit 6 of the status byte flips between successive reads. Once the operation ends, reads return the true stored byte and stop changing.
- R11: The device stays busy for PROG_CYCLES clock cycles after a program write (default 8) and ERASE_CYCLES cycles after an erase (default 40). Writes that arrive while it is busy are ignored.
- R12: A write is counted once, in the first clock cycle in which `ce_n` and `we_n` are both low. Holding the strobe low adds no further writes, and `we_n` low with `ce_n` high is no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W (18) | Byte address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data or status byte |
| dout_oe | output | 1 | Drive enable for the data bus |

## Verification
A decoder stuck in a step other than idle shows up on the first program or erase the host tries: the target byte reads back unchanged and no busy status appears. A corrupted busy counter shows at the ports one cycle past the expected end of the operation. There, the status byte appears either too long or too short, seen as bit 7 still inverted or bit 6 still flipping when the true data is due. A lost or early boot lock, or a wrong mode flag, shows up on the next read of a boot byte or of the identification addresses after the next erase or program.

// File: rtl/pflash_pkg.sv
// Package: shared constants and types for the flash command controller.
// Assumes key compares use a 15-bit address field.
package pflash_pkg;

    localparam int KEY_AW = 15;

    localparam logic [KEY_AW-1:0] KEY_ADDR_A = 15'h5555;
    localparam logic [KEY_AW-1:0] KEY_ADDR_B = 15'h2AAA;

    localparam logic [7:0] KEY_D1      = 8'hAA;
    localparam logic [7:0] KEY_D2      = 8'h55;
    localparam logic [7:0] OP_PROGRAM  = 8'hA0;
    localparam logic [7:0] OP_SETUP    = 8'h80;
    localparam logic [7:0] OP_ERASE    = 8'h10;
    localparam logic [7:0] OP_LOCK     = 8'h40;
    localparam logic [7:0] OP_ID_ENTER = 8'h90;
    localparam logic [7:0] OP_ID_EXIT  = 8'hF0;

    localparam logic [7:0] ID_MAKER    = 8'hDA;
    localparam logic [7:0] ID_PART     = 8'h8C;

    // Decoder position within a key sequence
    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_KEY1,
        SQ_KEY2,
        SQ_PROG_ARM,
        SQ_EXT1,
        SQ_EXT2,
        SQ_EXT3
    } seq_state_t;

    // One-cycle command pulses issued by the decoder
    typedef struct packed {
        logic prog;
        logic erase;
        logic lock;
        logic id_on;
        logic id_off;
    } cmd_t;

endpackage

// File: rtl/pflash_seq_decoder.sv
// Sequence decoder: follows key writes and issues one-cycle command pulses
// in the cycle of the final write of each sequence.
// Assumes wr_stb is already a single-cycle, busy-gated write event.
module pflash_seq_decoder
    import pflash_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [KEY_AW-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output cmd_t              cmd
);

    seq_state_t st_q, st_d;

    logic hit_a, hit_b;
    assign hit_a = (wr_addr == KEY_ADDR_A);
    assign hit_b = (wr_addr == KEY_ADDR_B);

    // Next step and command pulse for the current write
    always_comb begin
        st_d = st_q;
        cmd  = '0;
        if (wr_stb) begin
            st_d = SQ_IDLE;
            case (st_q)
                SQ_IDLE:     if (hit_a && wr_data == KEY_D1) st_d = SQ_KEY1;
                SQ_KEY1:     if (hit_b && wr_data == KEY_D2) st_d = SQ_KEY2;
                SQ_KEY2: begin
                    if (hit_a) begin
                        case (wr_data)
                            OP_PROGRAM:  st_d = SQ_PROG_ARM;
                            OP_SETUP:    st_d = SQ_EXT1;
                            OP_ID_ENTER: cmd.id_on  = 1'b1;
                            OP_ID_EXIT:  cmd.id_off = 1'b1;
                            default:     st_d = SQ_IDLE;
                        endcase
                    end
                end
                SQ_PROG_ARM: cmd.prog = 1'b1;
                SQ_EXT1:     if (hit_a && wr_data == KEY_D1) st_d = SQ_EXT2;
                SQ_EXT2:     if (hit_b && wr_data == KEY_D2) st_d = SQ_EXT3;
                SQ_EXT3: begin
                    if (hit_a && wr_data == OP_ERASE) cmd.erase = 1'b1;
                    if (hit_a && wr_data == OP_LOCK)  cmd.lock  = 1'b1;
                end
                default:     st_d = SQ_IDLE;
            endcase
        end
    end

    // Sequence state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= SQ_IDLE;
        else        st_q <= st_d;
    end

    // At most one command per write (R3, R5, R6, R7, R8)
    assert_one_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmd));

    // A pulse leaves the decoder back at idle (R4)
    assert_back_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|cmd) |=> (st_q == SQ_IDLE));

endmodule

// File: rtl/pflash_busy_timer.sv
// Busy timer: stands in for internal program and erase time with a
// down-counter. Busy is high while the count is nonzero.
// Assumes at most one start per cycle and no start while busy.
module pflash_busy_timer #(
    parameter int PROG_CYCLES  = 8,
    parameter int ERASE_CYCLES = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_prog,
    input  logic start_erase,
    output logic busy
);

    localparam int MAX_CYC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic [CNT_W-1:0] cnt_q;

    // Load on start, otherwise count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt_q <= '0;
        else if (start_erase) cnt_q <= CNT_W'(ERASE_CYCLES);
        else if (start_prog)  cnt_q <= CNT_W'(PROG_CYCLES);
        else if (cnt_q != '0) cnt_q <= cnt_q - CNT_W'(1);
    end

    assign busy = (cnt_q != '0);

    // A start always makes the device busy next cycle (R11)
    assert_start_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (start_prog || start_erase) |=> busy);

    // Without a start, a busy count steps down by one (R11)
    assert_countdown_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !start_prog && !start_erase) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

endmodule

// File: rtl/pflash_cell_array.sv
// Cell array: register storage with an AND-only program path and a bulk
// erase to FF. Boot bytes are held when the lock is set.
// Assumes prog_en and erase_en are never high together.
module pflash_cell_array #(
    parameter int MEM_AW  = 6,
    parameter int BOOT_AW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_en,
    input  logic [MEM_AW-1:0] prog_idx,
    input  logic [7:0]        prog_data,
    input  logic              erase_en,
    input  logic              lock,
    input  logic [MEM_AW-1:0] rd_idx,
    output logic [7:0]        rd_data
);

    localparam int DEPTH      = 1 << MEM_AW;
    localparam int BOOT_BYTES = 1 << BOOT_AW;

    logic [7:0] mem [DEPTH];

    // Reset to erased, clear bits on program, set all on erase
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) begin
                mem[i] <= 8'hFF;
            end else if (!(lock && (i < BOOT_BYTES))) begin
                if (prog_en && (prog_idx == MEM_AW'(i)))
                    mem[i] <= mem[i] & prog_data;
                else if (erase_en)
                    mem[i] <= 8'hFF;
            end
        end
    end

    assign rd_data = mem[rd_idx];

    // Boot bytes hold still once locked (R6)
    for (genvar b = 0; b < BOOT_BYTES; b++) begin : g_boot_chk
        assert_boot_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
            lock |=> $stable(mem[b]));
    end

endmodule

// File: rtl/pflash_seq_ctrl.sv
// Top: strobe edge detection, mode and lock flags, status byte and read mux.
// Assumes strobes are synchronous to clk. The data bus is split into
// dout and dout_oe for a pad-level tristate.
module pflash_seq_ctrl
    import pflash_pkg::*;
#(
    parameter int ADDR_W       = 18,
    parameter int MEM_AW       = 6,
    parameter int BOOT_AW      = 4,
    parameter int PROG_CYCLES  = 8,
    parameter int ERASE_CYCLES = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic [7:0]        dout,
    output logic              dout_oe
);

    logic we_idle_q, rd_idle_q;
    logic wr_stb, rd_stb, busy;
    logic lock_q, id_q, tog_q, last7_q;
    logic [7:0] arr_data, id_data;
    cmd_t cmd;

    logic unused_addr_hi;
    assign unused_addr_hi = &{1'b0, addr[ADDR_W-1:KEY_AW]};

    // Track the previous strobe levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_idle_q <= 1'b1;
            rd_idle_q <= 1'b1;
        end else begin
            we_idle_q <= ce_n | we_n;
            rd_idle_q <= ce_n | oe_n;
        end
    end

    assign wr_stb = !ce_n && !we_n && we_idle_q && !busy;
    assign rd_stb = !ce_n && !oe_n && rd_idle_q;

    pflash_seq_decoder u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (wr_stb),
        .wr_addr (addr[KEY_AW-1:0]),
        .wr_data (din),
        .cmd     (cmd)
    );

    pflash_busy_timer #(
        .PROG_CYCLES  (PROG_CYCLES),
        .ERASE_CYCLES (ERASE_CYCLES)
    ) u_tmr (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_prog  (cmd.prog),
        .start_erase (cmd.erase),
        .busy        (busy)
    );

    pflash_cell_array #(
        .MEM_AW  (MEM_AW),
        .BOOT_AW (BOOT_AW)
    ) u_arr (
        .clk       (clk),
        .rst_n     (rst_n),
        .prog_en   (cmd.prog),
        .prog_idx  (addr[MEM_AW-1:0]),
        .prog_data (din),
        .erase_en  (cmd.erase),
        .lock      (lock_q),
        .rd_idx    (addr[MEM_AW-1:0]),
        .rd_data   (arr_data)
    );

    // Mode flags, status source bit and read toggle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q  <= 1'b0;
            id_q    <= 1'b0;
            tog_q   <= 1'b0;
            last7_q <= 1'b0;
        end else begin
            if (cmd.lock)   lock_q  <= 1'b1;
            if (cmd.id_on)  id_q    <= 1'b1;
            if (cmd.id_off) id_q    <= 1'b0;
            if (cmd.prog)   last7_q <= din[7];
            if (cmd.erase)  last7_q <= 1'b1;
            if (rd_stb && busy) tog_q <= ~tog_q;
        end
    end

    // Identification read values
    always_comb begin
        id_data = 8'h00;
        if (addr[KEY_AW-1:2] == '0) begin
            case (addr[1:0])
                2'd0:    id_data = ID_MAKER;
                2'd1:    id_data = ID_PART;
                2'd2:    id_data = {7'b0, lock_q};
                default: id_data = 8'h00;
            endcase
        end
    end

    // Read data select: status first, then ID, then array
    always_comb begin
        dout_oe = !ce_n && !oe_n;
        dout    = 8'h00;
        if (dout_oe) begin
            if (busy)      dout = {~last7_q, tog_q, 6'b0};
            else if (id_q) dout = id_data;
            else           dout = arr_data;
        end
    end

    // The boot lock never clears outside reset (R6)
    assert_lock_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> lock_q);

endmodule

// File: tb/pflash_seq_ctrl_bench.sv
`timescale 1ns/1ps
module pflash_seq_ctrl_bench;

    localparam int PROG_CYC  = 8;
    localparam int ERASE_CYC = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [17:0] addr = '0;
    logic [7:0]  din = '0;
    logic [7:0]  dout;
    logic        dout_oe;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    pflash_seq_ctrl #(.PROG_CYCLES(PROG_CYC), .ERASE_CYCLES(ERASE_CYC)) u_pflash_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe)
    );

    // Vector: {op[39:38], req[37:34], addr[33:16], data[15:8], expect[7:0]}
    localparam logic [1:0] OW = 2'd0, OR = 2'd1, OT = 2'd2;
    localparam int NV = 57;
    localparam logic [39:0] VEC [NV] = '{
        {OR, 4'd1, 18'h00010, 8'h00, 8'hFF},              // R1 erased after reset
        {OW, 4'd3, 18'h05555, 8'hAA, 8'h00},              // R3 program 05 <- 3C
        {OW, 4'd3, 18'h02AAA, 8'h55, 8'h00},
        {OW, 4'd3, 18'h05555, 8'hA0, 8'h00},
        {OW, 4'd3, 18'h00005, 8'h3C, 8'h00},
        {OT, 4'd3, 18'h00000, 8'h00, 8'h00},
        {OR, 4'd3, 18'h00005, 8'h00, 8'h3C},
        {OW, 4'd3, 18'h05555, 8'hAA, 8'h00},              // R3 AND with 17
        {OW, 4'd3, 18'h02AAA, 8'h55, 8'h00},
        {OW, 4'd3, 18'h05555, 8'hA0, 8'h00},
        {OW, 4'd3, 18'h00005, 8'h17, 8'h00},
        {OT, 4'd3, 18'h00000, 8'h00, 8'h00},
        {OR, 4'd3, 18'h00005, 8'h00, 8'h14},
        {OW, 4'd4, 18'h05555, 8'hAA, 8'h00},              // R4 broken key
        {OW, 4'd4, 18'h02AAA, 8'h00, 8'h00},
        {OW, 4'd4, 18'h05555, 8'hA0, 8'h00},
        {OW, 4'd4, 18'h00011, 8'h00, 8'h00},
        {OR, 4'd4, 18'h00011, 8'h00, 8'hFF},
        {OW, 4'd3, 18'h2D555, 8'hAA, 8'h00},              // R3 upper address bits ignored
        {OW, 4'd3, 18'h1AAAA, 8'h55, 8'h00},
        {OW, 4'd3, 18'h2D555, 8'hA0, 8'h00},
        {OW, 4'd3, 18'h00012, 8'h55, 8'h00},
        {OT, 4'd3, 18'h00000, 8'h00, 8'h00},
        {OR, 4'd3, 18'h00012, 8'h00, 8'h55},
        {OW, 4'd7, 18'h05555, 8'hAA, 8'h00},              // R7 ID mode
        {OW, 4'd7, 18'h02AAA, 8'h55, 8'h00},
        {OW, 4'd7, 18'h05555, 8'h90, 8'h00},
        {OR, 4'd7, 18'h00000, 8'h00, 8'hDA},
        {OR, 4'd7, 18'h00001, 8'h00, 8'h8C},
        {OR, 4'd7, 18'h00002, 8'h00, 8'h00},
        {OR, 4'd7, 18'h00003, 8'h00, 8'h00},
        {OW, 4'd8, 18'h05555, 8'hAA, 8'h00},              // R8 ID exit
        {OW, 4'd8, 18'h02AAA, 8'h55, 8'h00},
        {OW, 4'd8, 18'h05555, 8'hF0, 8'h00},
        {OR, 4'd8, 18'h00005, 8'h00, 8'h14},
        {OW, 4'd6, 18'h05555, 8'hAA, 8'h00},              // R6 set lock
        {OW, 4'd6, 18'h02AAA, 8'h55, 8'h00},
        {OW, 4'd6, 18'h05555, 8'h80, 8'h00},
        {OW, 4'd6, 18'h05555, 8'hAA, 8'h00},
        {OW, 4'd6, 18'h02AAA, 8'h55, 8'h00},
        {OW, 4'd6, 18'h05555, 8'h40, 8'h00},
        {OW, 4'd6, 18'h05555, 8'hAA, 8'h00},              // R6 program locked byte
        {OW, 4'd6, 18'h02AAA, 8'h55, 8'h00},
        {OW, 4'd6, 18'h05555, 8'hA0, 8'h00},
        {OW, 4'd6, 18'h00005, 8'h00, 8'h00},
        {OT, 4'd6, 18'h00000, 8'h00, 8'h00},
        {OR, 4'd6, 18'h00005, 8'h00, 8'h14},
        {OW, 4'd5, 18'h05555, 8'hAA, 8'h00},              // R5 chip erase
        {OW, 4'd5, 18'h02AAA, 8'h55, 8'h00},
        {OW, 4'd5, 18'h05555, 8'h80, 8'h00},
        {OW, 4'd5, 18'h05555, 8'hAA, 8'h00},
        {OW, 4'd5, 18'h02AAA, 8'h55, 8'h00},
        {OW, 4'd5, 18'h05555, 8'h10, 8'h00},
        {OT, 4'd5, 18'h00000, 8'h00, 8'h00},
        {OR, 4'd5, 18'h00012, 8'h00, 8'hFF},
        {OR, 4'd6, 18'h00005, 8'h00, 8'h14},              // R6 boot byte kept
        {OR, 4'd5, 18'h00011, 8'h00, 8'hFF}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // Called at a negedge; one write, then an idle cycle
    task automatic wr(input logic [17:0] a, input logic [7:0] d);
        ce_n = 1'b0; we_n = 1'b0; addr = a; din = d;
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
        @(negedge clk);
    endtask

    // Called at a negedge; samples mid-cycle, then an idle cycle
    task automatic rd(input logic [17:0] a, output logic [7:0] d, output logic oe);
        ce_n = 1'b0; oe_n = 1'b0; addr = a;
        #5;
        d = dout; oe = dout_oe;
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic key3(input logic [7:0] op);
        wr(18'h05555, 8'hAA); wr(18'h02AAA, 8'h55); wr(18'h05555, op);
    endtask

    task automatic key6(input logic [7:0] op);
        key3(8'h80); wr(18'h05555, 8'hAA); wr(18'h02AAA, 8'h55); wr(18'h05555, op);
    endtask

    initial begin : watchdog
        #(200000 * 20);
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        logic [7:0] d, d2;
        logic oe;
        string tag;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: no drive with output enable high, or with chip enable high
        #5;
        check("R2 idle oe", {7'b0, dout_oe}, 8'h00);
        check("R2 idle data", dout, 8'h00);
        ce_n = 1'b1; oe_n = 1'b0;
        #1;
        check("R2 ce high", {7'b0, dout_oe}, 8'h00);
        oe_n = 1'b1;
        @(negedge clk);
        rd(18'h00000, d, oe);
        check("R2 drive on read", {7'b0, oe}, 8'h01);
        check("R1 byte 0 erased", d, 8'hFF);

        // Vector walk
        for (int i = 0; i < NV; i++) begin
            case (VEC[i][39:38])
                OW: wr(VEC[i][33:16], VEC[i][15:8]);
                OT: repeat (ERASE_CYC + 4) @(negedge clk);
                default: begin
                    rd(VEC[i][33:16], d, oe);
                    tag = $sformatf("R%0d vec %0d", VEC[i][37:34], i);
                    check(tag, d, VEC[i][7:0]);
                end
            endcase
        end

        // R6/R7: lock visible in identification mode
        key3(8'h90);
        rd(18'h00002, d, oe);
        check("R6 lock in ID bit0", d, 8'h01);
        key3(8'hF0);

        // R9/R10: program 30 <- 00 gives inverted bit 7 and a toggling bit 6
        key3(8'hA0); wr(18'h00030, 8'h00);
        rd(18'h00030, d, oe);
        check("R9 status bit7", {7'b0, d[7]}, 8'h01);
        check("R9 status low bits", {2'b0, d[5:0]}, 8'h00);
        rd(18'h00030, d2, oe);
        check("R10 bit6 flips", {7'b0, d2[6]}, {7'b0, ~d[6]});
        repeat (PROG_CYC + 2) @(negedge clk);
        rd(18'h00030, d, oe);
        rd(18'h00030, d2, oe);
        check("R10 true data after", d, 8'h00);
        check("R10 stable after", d2, d);

        // R11: program length edge, bit 7 of 7F is 0 so status shows 1
        key3(8'hA0); wr(18'h00031, 8'h7F);
        repeat (PROG_CYC - 2) @(negedge clk);
        rd(18'h00031, d, oe);
        check("R11 busy last cycle", {7'b0, d[7]}, 8'h01);
        ce_n = 1'b0; oe_n = 1'b0; addr = 18'h00031;
        #5;
        check("R11 done after PROG_CYCLES", dout, 8'h7F);
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);

        // R9/R11: erase status and writes ignored while busy
        key6(8'h10);
        rd(18'h00031, d, oe);
        check("R9 erase status bit7", {7'b0, d[7]}, 8'h00);
        key3(8'hA0); wr(18'h00032, 8'h00);
        repeat (ERASE_CYC + 4) @(negedge clk);
        rd(18'h00032, d, oe);
        check("R11 busy write ignored", d, 8'hFF);
        rd(18'h00031, d, oe);
        check("R5 second erase", d, 8'hFF);

        // R12: held strobe counts once
        wr(18'h05555, 8'hAA);
        ce_n = 1'b0; we_n = 1'b0; addr = 18'h02AAA; din = 8'h55;
        repeat (3) @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
        @(negedge clk);
        wr(18'h05555, 8'hA0); wr(18'h00033, 8'h0F);
        repeat (PROG_CYC + 2) @(negedge clk);
        rd(18'h00033, d, oe);
        check("R12 held strobe once", d, 8'h0F);

        // R12: we_n low with ce_n high is no write
        wr(18'h05555, 8'hAA);
        ce_n = 1'b1; we_n = 1'b0; addr = 18'h00000; din = 8'h00;
        @(negedge clk);
        we_n = 1'b1;
        @(negedge clk);
        wr(18'h02AAA, 8'h55); wr(18'h05555, 8'hA0); wr(18'h00034, 8'h3C);
        repeat (PROG_CYC + 2) @(negedge clk);
        rd(18'h00034, d, oe);
        check("R12 no write without ce", d, 8'h3C);

        // R1: reset clears the lock and refills the array
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd(18'h00005, d, oe);
        check("R1 reset array", d, 8'hFF);
        key3(8'h90);
        rd(18'h00002, d, oe);
        check("R1 reset lock", d, 8'h00);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule